// File: doc/BRIEF.md
# Strobed Test Pulse Pattern Sequencer

This block drives a bank of test-pulse enable lines from a small pattern memory. A host fills the memory word by word. Each word holds one bit per output line and a loop marker. An external strobe steps through the memory one word per strobe. Every word is masked per channel with an enable vector and sent to the output lines a fixed number of clock cycles after the strobe begins.

A global enable can silence every output at once. The loop marker sets the length of a repeating pattern. A memory without any marker runs through all of its entries and then starts again. A host write with a dedicated command bit set does not store a word. It only returns the read pointer to the first entry, so a pattern can be restarted at any time.

The outputs keep their value between strobes. Changing the mask or the memory affects only the words taken by later strobes.

Top module: `tp_pattern_seq`

## Requirements
- R1: After reset all output lines are 0 and the read pointer is at address 0, so the first strobe presents the word stored at address 0.
- R2: A host write with data bit 25 clear stores data bits 21:0 as the line pattern and data bit 24 as the loop marker at the given address.
- R3: A strobe acts on its rising edge only. A strobe held high for many cycles advances the pointer exactly once.
- R4: For a strobe first sampled high at clock edge k, the outputs take the value (pattern at the pointer) AND (channel mask sampled at edge k) at edge k+1, which is 2 cycles after the strobe starts.
- R5: A word with the loop marker (bit 24) set is the last word of the pattern. The strobe that presents it returns the pointer to address 0.
- R6: With no loop marker set anywhere, the pointer moves from address 127 to address 0.
- R7: While the global enable is 0, the outputs are 0 from the next clock edge on. Strobes still advance the pointer during that time. The outputs stay 0 after the enable returns, until the next strobe.
- R8: A host write with data bit 25 set resets the read pointer to 0 and leaves the memory unchanged.
- R9: When a pointer-reset write and a strobe edge fall in the same cycle, that strobe presents the word at the old pointer and the pointer still ends at 0. The next strobe then presents address 0.
- R10: Between strobes the outputs hold their value, even when the channel mask changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (20 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 7 | Host write address |
| wr_data | input | 32 | Host write data: 21:0 pattern, 24 loop marker, 25 pointer-reset command |
| chan_mask | input | 22 | Per-channel output enable mask |
| pulse_en | input | 1 | Global test-pulse enable |
| strobe | input | 1 | External step strobe, active high |
| tp_out | output | 22 | Test-pulse enable lines |

## Verification
Two functions can land in the same cycle: the rising edge of a strobe and a pointer-reset write. The bench raises the strobe and issues the reset command on the same falling clock edge. It expects the output to show the word from the old pointer two edges later, and the following strobe to show address 0. A second overlap comes from dropping the global enable while strobes keep arriving. The bench judges it by lines that stay at zero and by the pointer position seen once the enable returns.

// File: rtl/tp_seq_pkg.sv
package tp_seq_pkg;
   localparam int TP_LINES_DEF      = 22;
   localparam int TP_DEPTH_DEF      = 128;
   localparam int TP_DATA_W_DEF     = 32;
   localparam int TP_LOOP_BIT_DEF   = 24;
   localparam int TP_CMD_BIT_DEF    = 25;
   localparam int TP_DELAY_DEF      = 2;

   typedef enum logic [1:0] {
      PTR_HOLD  = 2'd0,
      PTR_NEXT  = 2'd1,
      PTR_ZERO  = 2'd2
   } ptr_op_e;
endpackage

// File: rtl/tp_strobe_edge.sv
module tp_strobe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   output logic rise_o
);
   logic strobe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= strobe_i;
   end

   assign rise_o = strobe_i & ~strobe_q;

   // R3
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/tp_pattern_store.sv
module tp_pattern_store
   import tp_seq_pkg::*;
#(
   parameter int LINES    = TP_LINES_DEF,
   parameter int DEPTH    = TP_DEPTH_DEF,
   parameter int DATA_W   = TP_DATA_W_DEF,
   parameter int LOOP_BIT = TP_LOOP_BIT_DEF,
   parameter int CMD_BIT  = TP_CMD_BIT_DEF,
   localparam int ADDR_W  = $clog2(DEPTH),
   localparam int ENTRY_W = LINES + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              step_i,
   output logic [LINES-1:0]  word_o
);
   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0]  ptr;
   logic [ENTRY_W-1:0] cur;
   logic               cmd, store, last;
   ptr_op_e            op;

   assign cmd   = wr_en_i &  wr_data_i[CMD_BIT];
   assign store = wr_en_i & ~wr_data_i[CMD_BIT];
   assign cur   = mem[ptr];
   assign last  = cur[LINES] | (ptr == ADDR_W'(DEPTH - 1));
   assign word_o = cur[LINES-1:0];

   always_ff @(posedge clk) begin
      if (store) mem[wr_addr_i] <= {wr_data_i[LOOP_BIT], wr_data_i[LINES-1:0]};
   end

   always_comb begin
      if (cmd)                op = PTR_ZERO;
      else if (step_i && last) op = PTR_ZERO;
      else if (step_i)        op = PTR_NEXT;
      else                    op = PTR_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ptr <= '0;
      else begin
         case (op)
            PTR_ZERO: ptr <= '0;
            PTR_NEXT: ptr <= ptr + ADDR_W'(1);
            default:  ptr <= ptr;
         endcase
      end
   end

   // R3
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !cmd) |=> $stable(ptr));
   // R8
   ptr_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd |=> (ptr == '0));
   // R5
   ptr_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && cur[LINES]) |=> (ptr == '0));
   // R3
   ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !cmd && !cur[LINES] && ptr != ADDR_W'(DEPTH - 1))
         |=> (ptr == $past(ptr) + ADDR_W'(1)));
endmodule

// File: rtl/tp_out_stage.sv
module tp_out_stage
   import tp_seq_pkg::*;
#(
   parameter int LINES = TP_LINES_DEF,
   parameter int DELAY = TP_DELAY_DEF,
   localparam int STAGES = DELAY - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LINES-1:0] data_i,
   input  logic             pulse_en_i,
   output logic [LINES-1:0] tp_o
);
   logic [LINES-1:0] pd [STAGES];
   logic             pv [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pv[0] <= 1'b0;
         pd[0] <= '0;
      end else begin
         pv[0] <= load_i;
         if (load_i) pd[0] <= data_i;
      end
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_dly
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pv[s] <= 1'b0;
            pd[s] <= '0;
         end else begin
            pv[s] <= pv[s-1];
            pd[s] <= pd[s-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)               tp_o <= '0;
      else if (!pulse_en_i)     tp_o <= '0;
      else if (pv[STAGES-1])    tp_o <= pd[STAGES-1];
   end

   // R7
   off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_en_i |=> (tp_o == '0));
   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_en_i && !pv[STAGES-1]) |=> $stable(tp_o));
endmodule

// File: rtl/tp_pattern_seq.sv
module tp_pattern_seq
   import tp_seq_pkg::*;
#(
   parameter int LINES    = TP_LINES_DEF,
   parameter int DEPTH    = TP_DEPTH_DEF,
   parameter int DATA_W   = TP_DATA_W_DEF,
   parameter int LOOP_BIT = TP_LOOP_BIT_DEF,
   parameter int CMD_BIT  = TP_CMD_BIT_DEF,
   parameter int DELAY    = TP_DELAY_DEF,
   localparam int ADDR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LINES-1:0]  chan_mask,
   input  logic              pulse_en,
   input  logic              strobe,
   output logic [LINES-1:0]  tp_out
);
   initial begin : param_chk
      assert (DELAY >= 2 && LOOP_BIT >= LINES && CMD_BIT >= LINES &&
              LOOP_BIT != CMD_BIT && CMD_BIT < DATA_W && LOOP_BIT < DATA_W &&
              DEPTH >= 2)
         else $error("tp_pattern_seq: inconsistent parameters");
   end

   logic             rise;
   logic [LINES-1:0] word;

   tp_strobe_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (strobe),
      .rise_o   (rise)
   );

   tp_pattern_store #(
      .LINES    (LINES),
      .DEPTH    (DEPTH),
      .DATA_W   (DATA_W),
      .LOOP_BIT (LOOP_BIT),
      .CMD_BIT  (CMD_BIT)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .step_i    (rise),
      .word_o    (word)
   );

   tp_out_stage #(
      .LINES (LINES),
      .DELAY (DELAY)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (rise),
      .data_i     (word & chan_mask),
      .pulse_en_i (pulse_en),
      .tp_o       (tp_out)
   );
endmodule

// File: tb/sim_tp_pattern_seq.sv
module sim_tp_pattern_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [6:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [21:0] chan_mask = '1;
   logic        pulse_en = 1'b0;
   logic        strobe = 1'b0;
   logic [21:0] tp_out;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [21:0] got;

   always #2.5 clk = ~clk;

   tp_pattern_seq u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .chan_mask(chan_mask), .pulse_en(pulse_en),
      .strobe(strobe), .tp_out(tp_out)
   );

   function automatic logic [21:0] pat(int a);
      logic [31:0] h;
      h = (32'(a) + 32'd7) * 32'h9E3779B1;
      return h[26:5] | 22'h1;
   endfunction

   function automatic logic [21:0] msk(int a);
      logic [31:0] h;
      h = (32'(a) + 32'd3) * 32'h6A09E667;
      return (a % 3 == 0) ? 22'h3FFFFF : h[28:7];
   endfunction

   task automatic chk(string req, logic [21:0] act, logic [21:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_wr(int a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 7'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ptr_reset();
      host_wr(0, 32'h0200_0000);
   endtask

   task automatic do_strobe(int hold, output logic [21:0] q);
      @(negedge clk);
      strobe = 1'b1;
      @(negedge clk);
      @(negedge clk);
      q = tp_out;
      repeat (hold) @(negedge clk);
      strobe = 1'b0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [21:0] g2;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset output", tp_out, 22'h0);

      // R2: fill without loop markers
      for (int a = 0; a < 128; a++) host_wr(a, {10'h0, pat(a)});
      pulse_en = 1'b1;
      chan_mask = '1;

      // R1 R4: first strobe shows address 0
      do_strobe(3, got);
      chk("R1 first word", got, pat(0));
      // R4 R3: sweep with varying masks
      for (int a = 1; a < 128; a++) begin
         chan_mask = msk(a);
         do_strobe(3, got);
         chk("R4 masked word", got, pat(a) & msk(a));
      end
      // R6: natural wrap
      chan_mask = '1;
      do_strobe(3, got);
      chk("R6 wrap 127 to 0", got, pat(0));

      // R3: long strobe advances once
      do_strobe(25, got);
      chk("R3 long strobe", got, pat(1));
      do_strobe(3, got);
      chk("R3 single advance", got, pat(2));

      // R10: mask change between strobes
      chan_mask = 22'h0;
      repeat (6) @(negedge clk);
      chk("R10 hold", tp_out, pat(2));
      chan_mask = '1;

      // R8: command write leaves memory untouched
      host_wr(9, 32'h0215_5555);
      for (int a = 0; a < 10; a++) begin
         do_strobe(3, got);
         chk("R8 reset and keep memory", got, pat(a));
      end

      // R5: loop marker at address 3
      host_wr(3, {7'h0, 1'b1, 2'b0, pat(3)});
      ptr_reset();
      for (int a = 0; a < 4; a++) begin
         do_strobe(3, got);
         chk("R5 before marker", got, pat(a));
      end
      do_strobe(3, got);
      chk("R5 loop back", got, pat(0));
      do_strobe(3, got);
      chk("R5 after loop", got, pat(1));

      // R7: global enable off
      @(negedge clk);
      pulse_en = 1'b0;
      @(negedge clk);
      chk("R7 forced zero", tp_out, 22'h0);
      do_strobe(3, got);
      chk("R7 zero during strobe", got, 22'h0);
      pulse_en = 1'b1;
      repeat (3) @(negedge clk);
      chk("R7 zero until strobe", tp_out, 22'h0);
      do_strobe(3, got);
      chk("R7 pointer kept moving", got, pat(3));

      // R9: strobe edge and pointer reset together (pointer at 0 after loop)
      do_strobe(3, got);
      chk("R9 setup", got, pat(0));
      @(negedge clk);
      strobe = 1'b1;
      wr_en = 1'b1; wr_addr = 7'd0; wr_data = 32'h0200_0000;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      chk("R9 old word shown", tp_out, pat(1));
      repeat (3) @(negedge clk);
      strobe = 1'b0;
      @(negedge clk);
      do_strobe(3, got);
      chk("R9 next from zero", got, pat(0));

      // R2: overwrite one entry and read it back
      g2 = 22'h2A5C3E;
      host_wr(2, {10'h0, g2});
      ptr_reset();
      for (int a = 0; a < 3; a++) begin
         do_strobe(3, got);
         chk("R2 stored word", got, (a == 2) ? g2 : pat(a));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule